// File: doc/BRIEF.md
# Layer Coincidence Road Finder

This block looks for straight tracks crossing a six-layer cathode chamber section that is sixteen strips wide. Each layer supplies 32 hit bits, one for every half-strip position. A new set of bits arrives on each bunch clock together with a strobe and a time stamp. Hits are stretched over a programmable number of clocks, so that layers whose signals arrive a little late can still line up with the others. On every strobe the block scores each possible road, meaning each combination of key half-strip and slope pattern, by the number of layers that hold an active hit on that road.

The best road is reported three clocks after the strobe. It is reported only if it covers at least a programmable minimum number of layers. The report gives the key half-strip, the slope code, the layer count and the time stamp of the strobe. A downstream trigger stage takes one candidate per clock and uses the valid flag to qualify it.

Top module: `layer_road_finder`

## Requirements
- R1: While reset is asserted and until the first strobe has moved through the pipeline, `cand_valid_o` and every candidate field read zero.
- R2: A strobe sampled at a rising edge produces its result on the outputs after three rising edges, counting that one. `cand_time_o` then equals the `stamp_i` value sampled with that strobe.
- R3: `cand_valid_o` is 1 only for results of strobe cycles, and only when the best layer count is at least the effective minimum. The effective minimum is 1 when `min_layers_i` is 0 and is `min_layers_i` otherwise, so values above 6 never give a candidate.
- R4: The reported layer count equals the number of layers l (0 to 5) that hold an active hit at half-strip key + s·(l − 2), where the hit for layer l and half-strip h is bit l·32 + h of `hits_i`. Positions outside 0 to 31 do not count.
- R5: Slope code 0 means s = 0, code 1 means s = +1, code 2 means s = −1, code 3 means s = +2 and code 4 means s = −2. The key half-strip is the position on layer index 2.
- R6: A hit presented with the strobe stays active for evaluations d clocks later while d < max(1, `hold_i`). Hit bits presented while `strobe_i` is low are ignored.
- R7: Among competing roads, the one with more layers wins. On equal layer counts the lower slope code wins, and after that the lower key half-strip wins.
- R8: Whenever `cand_valid_o` is 0, `cand_key_o`, `cand_slope_o`, `cand_nlay_o` and `cand_time_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Marks a cycle whose hit bits are taken and evaluated |
| hits_i | input | 192 | Half-strip hits, bit l·32 + h for layer l, position h |
| stamp_i | input | 12 | Time stamp of the current cycle |
| min_layers_i | input | 3 | Minimum layer count for a candidate |
| hold_i | input | 3 | Clocks a hit stays active (0 acts as 1) |
| cand_valid_o | output | 1 | Candidate present |
| cand_key_o | output | 5 | Key half-strip on layer index 2 |
| cand_slope_o | output | 3 | Slope code 0 to 4 |
| cand_nlay_o | output | 3 | Number of layers on the road |
| cand_time_o | output | 12 | Time stamp of the originating strobe |

## Verification
Hit stretching and a fresh strobe can land in the same cycle. One evaluation then mixes hits that are still held from earlier strobes with the hits arriving now. Road selection can also see several roads with equal scores in that same evaluation. The bench provokes both by sending strobes back to back under holds of up to seven clocks, with dense random hits and planted roads. It also runs directed cases that split one road across two strobes whose spacing sits just inside and just outside the hold window. A bench model keeps, for every half-strip, the cycle of its last strobed hit, finds the winner by an explicit three-level comparison, and judges each field three clocks later.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

  localparam int NPAT  = 5;
  localparam int PAT_W = 3;

  // slope in half-strips per layer for a pattern code
  function automatic int slope_of(input int pat);
    if (pat == 0)          return 0;
    else if (pat % 2 == 1) return (pat + 1) / 2;
    else                   return -(pat / 2);
  endfunction

  // half-strip a road with this key and pattern crosses on a layer
  function automatic int tap_pos(input int key, input int pat, input int layer,
                                 input int key_layer);
    return key + slope_of(pat) * (layer - key_layer);
  endfunction

  // a programmed minimum of zero behaves like one
  function automatic int floor_one(input int v);
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/hit_stretch.sv
module hit_stretch #(
  parameter int NLAYER = 6,
  parameter int NHS    = 32,
  parameter int HOLD_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   strobe_i,
  input  logic [NLAYER*NHS-1:0]  hits_i,
  input  logic [HOLD_W-1:0]      hold_i,
  output logic [NLAYER*NHS-1:0]  act_o
);
  localparam int NBIT = NLAYER * NHS;

  logic [HOLD_W-1:0] hold_eff;
  assign hold_eff = (hold_i == '0) ? HOLD_W'(1) : hold_i;

  for (genvar b = 0; b < NBIT; b++) begin : g_bit
    logic [HOLD_W-1:0] life_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  life_q <= '0;
      else if (strobe_i && hits_i[b]) life_q <= hold_eff;
      else if (life_q != '0)        life_q <= life_q - HOLD_W'(1);
    end
    assign act_o[b] = (life_q != '0);
  end

endmodule

// File: rtl/road_count.sv
module road_count import lcr_pkg::*; #(
  parameter int NLAYER    = 6,
  parameter int NHS       = 32,
  parameter int KEY_LAYER = 2,
  parameter int CNT_W     = 3,
  parameter int TW        = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NLAYER*NHS-1:0]       act_i,
  input  logic                        valid_i,
  input  logic [TW-1:0]               stamp_i,
  output logic [NPAT*NHS*CNT_W-1:0]   cnt_o,
  output logic                        valid_o,
  output logic [TW-1:0]               stamp_o
);

  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    for (genvar k = 0; k < NHS; k++) begin : g_key
      logic [NLAYER-1:0] tap;
      logic [CNT_W-1:0]  sum_q;
      for (genvar l = 0; l < NLAYER; l++) begin : g_lay
        localparam int POS = tap_pos(k, p, l, KEY_LAYER);
        if (POS >= 0 && POS < NHS) begin : g_in
          assign tap[l] = act_i[l*NHS + POS];
        end else begin : g_out
          assign tap[l] = 1'b0;
        end
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sum_q <= '0;
        else         sum_q <= CNT_W'($countones(tap));
      end
      assign cnt_o[(p*NHS + k)*CNT_W +: CNT_W] = sum_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      stamp_o <= '0;
    end else begin
      valid_o <= valid_i;
      stamp_o <= stamp_i;
    end
  end

endmodule

// File: rtl/road_select.sv
module road_select import lcr_pkg::*; #(
  parameter int NHS   = 32,
  parameter int CNT_W = 3,
  parameter int KEY_W = 5,
  parameter int TW    = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NPAT*NHS*CNT_W-1:0]  cnt_i,
  input  logic                       valid_i,
  input  logic [TW-1:0]              stamp_i,
  input  logic [CNT_W-1:0]           min_i,
  output logic                       cand_valid_o,
  output logic [KEY_W-1:0]           cand_key_o,
  output logic [PAT_W-1:0]           cand_slope_o,
  output logic [CNT_W-1:0]           cand_nlay_o,
  output logic [TW-1:0]              cand_time_o
);

  logic [CNT_W-1:0] best_n, cur_n, min_eff;
  logic [PAT_W-1:0] best_p;
  logic [KEY_W-1:0] best_k;
  logic             pass;

  // pattern outer, key inner, strict improvement only: first maximum wins
  always_comb begin
    best_n = '0;
    best_p = '0;
    best_k = '0;
    cur_n  = '0;
    for (int p = 0; p < NPAT; p++) begin
      for (int k = 0; k < NHS; k++) begin
        cur_n = cnt_i[(p*NHS + k)*CNT_W +: CNT_W];
        if (cur_n > best_n) begin
          best_n = cur_n;
          best_p = PAT_W'(p);
          best_k = KEY_W'(k);
        end
      end
    end
  end

  assign min_eff = CNT_W'(floor_one(int'(min_i)));
  assign pass    = valid_i && (best_n >= min_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_valid_o <= 1'b0;
      cand_key_o   <= '0;
      cand_slope_o <= '0;
      cand_nlay_o  <= '0;
      cand_time_o  <= '0;
    end else if (pass) begin
      cand_valid_o <= 1'b1;
      cand_key_o   <= best_k;
      cand_slope_o <= best_p;
      cand_nlay_o  <= best_n;
      cand_time_o  <= stamp_i;
    end else begin
      cand_valid_o <= 1'b0;
      cand_key_o   <= '0;
      cand_slope_o <= '0;
      cand_nlay_o  <= '0;
      cand_time_o  <= '0;
    end
  end

endmodule

// File: rtl/layer_road_finder.sv
module layer_road_finder import lcr_pkg::*; #(
  parameter int NLAYER    = 6,
  parameter int NHS       = 32,
  parameter int KEY_LAYER = 2,
  parameter int TW        = 12,
  parameter int HOLD_W    = 3,
  localparam int CNT_W    = $clog2(NLAYER + 1),
  localparam int KEY_W    = $clog2(NHS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   strobe_i,
  input  logic [NLAYER*NHS-1:0]  hits_i,
  input  logic [TW-1:0]          stamp_i,
  input  logic [CNT_W-1:0]       min_layers_i,
  input  logic [HOLD_W-1:0]      hold_i,
  output logic                   cand_valid_o,
  output logic [KEY_W-1:0]       cand_key_o,
  output logic [PAT_W-1:0]       cand_slope_o,
  output logic [CNT_W-1:0]       cand_nlay_o,
  output logic [TW-1:0]          cand_time_o
);

  logic [NLAYER*NHS-1:0]     act_w;
  logic                      eval1_q;
  logic [TW-1:0]             stamp1_q;
  logic [NPAT*NHS*CNT_W-1:0] score_w;
  logic                      eval2_w;
  logic [TW-1:0]             stamp2_w;

  // stage 1: hit stretching, strobe and stamp alongside
  hit_stretch #(.NLAYER(NLAYER), .NHS(NHS), .HOLD_W(HOLD_W)) u_stretch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .hits_i  (hits_i),
    .hold_i  (hold_i),
    .act_o   (act_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eval1_q  <= 1'b0;
      stamp1_q <= '0;
    end else begin
      eval1_q  <= strobe_i;
      stamp1_q <= stamp_i;
    end
  end

  // stage 2: per-road layer counts
  road_count #(.NLAYER(NLAYER), .NHS(NHS), .KEY_LAYER(KEY_LAYER),
               .CNT_W(CNT_W), .TW(TW)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act_w),
    .valid_i(eval1_q),
    .stamp_i(stamp1_q),
    .cnt_o  (score_w),
    .valid_o(eval2_w),
    .stamp_o(stamp2_w)
  );

  // stage 3: best road and threshold
  road_select #(.NHS(NHS), .CNT_W(CNT_W), .KEY_W(KEY_W), .TW(TW)) u_select (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_i       (score_w),
    .valid_i     (eval2_w),
    .stamp_i     (stamp2_w),
    .min_i       (min_layers_i),
    .cand_valid_o(cand_valid_o),
    .cand_key_o  (cand_key_o),
    .cand_slope_o(cand_slope_o),
    .cand_nlay_o (cand_nlay_o),
    .cand_time_o (cand_time_o)
  );

endmodule

// File: rtl/road_finder_checker.sv
module road_finder_checker import lcr_pkg::*; #(
  parameter int NLAYER = 6,
  parameter int NHS    = 32,
  parameter int TW     = 12,
  parameter int CNT_W  = 3,
  parameter int KEY_W  = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  strobe_i,
  input logic [NLAYER*NHS-1:0] hits_i,
  input logic [TW-1:0]         stamp_i,
  input logic [CNT_W-1:0]      min_layers_i,
  input logic [NLAYER*NHS-1:0] act_i,
  input logic                  cand_valid_o,
  input logic [KEY_W-1:0]      cand_key_o,
  input logic [PAT_W-1:0]      cand_slope_o,
  input logic [CNT_W-1:0]      cand_nlay_o,
  input logic [TW-1:0]         cand_time_o
);

  logic [CNT_W-1:0] floor_min;
  assign floor_min = (min_layers_i == '0) ? CNT_W'(1) : min_layers_i;

  AST_HOLD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> ((act_i & $past(hits_i)) == $past(hits_i))); // R6

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_o |-> $past(strobe_i, 3)); // R2

  AST_TIME_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_o |-> (cand_time_o == $past(stamp_i, 3))); // R2

  AST_MIN_LAYERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_o |-> (cand_nlay_o >= $past(floor_min))); // R3

  AST_NLAY_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_nlay_o <= CNT_W'(NLAYER)); // R4

  AST_SLOPE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_o |-> (cand_slope_o < PAT_W'(NPAT))); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cand_valid_o |-> (cand_key_o == '0 && cand_slope_o == '0 &&
                       cand_nlay_o == '0 && cand_time_o == '0)); // R8

endmodule

bind layer_road_finder road_finder_checker #(
  .NLAYER(NLAYER), .NHS(NHS), .TW(TW), .CNT_W(CNT_W), .KEY_W(KEY_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .strobe_i    (strobe_i),
  .hits_i      (hits_i),
  .stamp_i     (stamp_i),
  .min_layers_i(min_layers_i),
  .act_i       (act_w),
  .cand_valid_o(cand_valid_o),
  .cand_key_o  (cand_key_o),
  .cand_slope_o(cand_slope_o),
  .cand_nlay_o (cand_nlay_o),
  .cand_time_o (cand_time_o)
);

// File: tb/layer_road_finder_test.sv
module layer_road_finder_test;
  localparam int NL = 6;
  localparam int NH = 32;
  localparam int KL = 2;
  localparam int TW = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              strobe;
  logic [NL*NH-1:0]  hits;
  logic [TW-1:0]     stamp;
  logic [2:0]        min_cfg;
  logic [2:0]        hold_cfg;
  logic              cv;
  logic [4:0]        key;
  logic [2:0]        slp;
  logic [2:0]        nlay;
  logic [TW-1:0]     tm;

  layer_road_finder uut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .hits_i(hits),
    .stamp_i(stamp), .min_layers_i(min_cfg), .hold_i(hold_cfg),
    .cand_valid_o(cv), .cand_key_o(key), .cand_slope_o(slp),
    .cand_nlay_o(nlay), .cand_time_o(tm)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;
  int last_hit [NL][NH];
  bit   armed [4];
  bit   ev [4];
  int   ek [4];
  int   es [4];
  int   en [4];
  int   et [4];

  function automatic int slope_for(input int code);
    case (code)
      1: return 1;
      2: return -1;
      3: return 2;
      4: return -2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [NL*NH-1:0] road(input int k, input int code, input int mask);
    logic [NL*NH-1:0] v = '0;
    for (int l = 0; l < NL; l++) begin
      int pos = k + slope_for(code) * (l - KL);
      if (mask[l] && pos >= 0 && pos < NH) v[l*NH + pos] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [NL*NH-1:0] noise(input int dens);
    logic [NL*NH-1:0] v = '0;
    for (int b = 0; b < NL*NH; b++) v[b] = (($urandom % dens) == 0);
    return v;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic verify_due();
    int i;
    if (cyc >= 3) begin
      i = (cyc - 3) % 4;
      if (armed[i]) begin
        chk(cv == ev[i], "R3 valid flag", int'(cv), int'(ev[i]));
        if (ev[i]) begin
          chk(int'(nlay) == en[i], "R4 layer count", int'(nlay), en[i]);
          chk(int'(slp) == es[i], "R5/R7 slope code", int'(slp), es[i]);
          chk(int'(key) == ek[i], "R7 key half-strip", int'(key), ek[i]);
          chk(int'(tm) == et[i], "R2 time tag", int'(tm), et[i]);
        end else begin
          chk(key == 0 && slp == 0 && nlay == 0 && tm == 0, "R8 idle fields zero",
              int'(key) + int'(slp) + int'(nlay) + int'(tm), 0);
        end
      end
    end
  endtask

  // one clock: check result due now, apply inputs, predict this cycle's result
  task automatic drive(input logic [NL*NH-1:0] h, input logic s, input logic [TW-1:0] st);
    int slot, he, me, bn, bs, bk, n, pos;
    @(negedge clk);
    verify_due();
    hits = h; strobe = s; stamp = st;
    slot = cyc % 4;
    he = (hold_cfg == 0) ? 1 : int'(hold_cfg);
    me = (min_cfg == 0) ? 1 : int'(min_cfg);
    if (s) begin
      for (int l = 0; l < NL; l++)
        for (int x = 0; x < NH; x++)
          if (h[l*NH + x]) last_hit[l][x] = cyc;
    end
    bn = 0; bs = 0; bk = 0;
    for (int k = 0; k < NH; k++) begin
      for (int c = 0; c < 5; c++) begin
        n = 0;
        for (int l = 0; l < NL; l++) begin
          pos = k + slope_for(c) * (l - KL);
          if (pos >= 0 && pos < NH && (cyc - last_hit[l][pos]) < he) n++;
        end
        if (n > bn || (n == bn && n > 0 && (c < bs || (c == bs && k < bk)))) begin
          bn = n; bs = c; bk = k;
        end
      end
    end
    armed[slot] = 1'b1;
    ev[slot] = s && (bn >= me);
    en[slot] = bn; es[slot] = bs; ek[slot] = bk; et[slot] = int'(st);
    cyc++;
  endtask

  task automatic set_cfg(input int mn, input int hd);
    repeat (10) drive('0, 1'b0, '0);
    min_cfg = 3'(mn);
    hold_cfg = 3'(hd);
  endtask

  initial begin
    for (int l = 0; l < NL; l++)
      for (int x = 0; x < NH; x++) last_hit[l][x] = -100;
    rst_n = 1'b0; strobe = 1'b0; hits = '0; stamp = '0;
    min_cfg = 3'd4; hold_cfg = 3'd3;
    strobe = 1'b1; hits = '1; stamp = 12'habc;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state with active-looking inputs
    chk(cv == 1'b0, "R1 reset valid", int'(cv), 0);
    chk(key == 0 && slp == 0 && nlay == 0 && tm == 0, "R1 reset fields",
        int'(key) + int'(slp) + int'(nlay) + int'(tm), 0);
    strobe = 1'b0; hits = '0; stamp = '0;
    rst_n = 1'b1;

    // R5/R4: every key and slope with a full road, lowest threshold
    set_cfg(1, 1);
    for (int c = 0; c < 5; c++)
      for (int k = 0; k < NH; k++)
        drive(road(k, c, 6'h3f), 1'b1, 12'(c*NH + k));
    // R3/R4: same sweep, only roads with all six layers in range qualify
    set_cfg(6, 1);
    for (int c = 0; c < 5; c++)
      for (int k = 0; k < NH; k++)
        drive(road(k, c, 6'h3f), 1'b1, 12'(100 + c*NH + k));

    // R6: road split over two strobes, spacing inside and outside the window
    set_cfg(6, 3);
    drive(road(10, 0, 6'h07), 1'b1, 12'd1);
    drive('0, 1'b0, '0);
    drive(road(10, 0, 6'h38), 1'b1, 12'd2);
    repeat (6) drive('0, 1'b0, '0);
    drive(road(12, 1, 6'h07), 1'b1, 12'd3);
    drive('0, 1'b0, '0);
    drive('0, 1'b0, '0);
    drive(road(12, 1, 6'h38), 1'b1, 12'd4);
    // R6: hits with strobe low are ignored
    set_cfg(1, 1);
    drive('1, 1'b0, 12'd5);
    drive('0, 1'b1, 12'd6);
    drive('0, 1'b1, 12'd7);

    // R7: ties on count, slope and key
    drive(road(7, 0, 6'h04) | road(20, 0, 6'h04), 1'b1, 12'd8);
    drive(road(20, 0, 6'h07) | road(5, 1, 6'h07), 1'b1, 12'd9);
    drive(road(18, 2, 6'h1e) | road(9, 1, 6'h1e), 1'b1, 12'd10);
    drive(road(3, 3, 6'h3c) | road(25, 0, 6'h1c), 1'b1, 12'd11);

    // random sweeps over threshold and hold settings
    for (int ph = 0; ph < 8; ph++) begin
      int mins [8] = '{0, 3, 4, 5, 6, 7, 2, 4};
      int holds[8] = '{1, 2, 3, 5, 7, 0, 4, 3};
      set_cfg(mins[ph], holds[ph]);
      repeat (250) begin
        logic [NL*NH-1:0] h = noise(10 + 3*ph);
        if (($urandom % 3) == 0)
          h = h | road(int'($urandom % NH), int'($urandom % 5), int'($urandom % 64));
        drive(h, ($urandom % 4) != 0, 12'($urandom));
      end
    end
    repeat (4) drive('0, 1'b0, '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule